// File: doc/BRIEF.md
# Multi-Channel PWM Timer

This block is a bus-mapped timer with several identical 16-bit counting channels and one shared register that starts and stops them. Each channel counts ticks taken from a prescaled copy of the system clock on a chosen edge. It can reset its count on one of four compare values, and it drives one output pin. The pin level is set by an output-control code that holds a starting level and an action applied on a compare match.

In PWM mode the pin starts each period at its starting level. It takes the match level when the count reaches compare A. It returns to the starting level on the compare that resets the counter. Software sets the period with the clearing compare and the duty with compare A. It can hold the pin at a steady 0 or 1 by writing an output code that has no match action. Register access uses a flat 16-bit bus with combinational read data.

Top module: `multi_timer_pwm`

## Requirements
- R1: The register at byte address 0x00 holds one run bit per channel, with bit n for channel n. It reads back as written. While a channel's run bit is 0 its counter keeps its value.
- R2: Channel n occupies byte addresses 0x10+n*0x40 upward. The channel offsets are: control 0x00 (all 16 bits read back), mode 0x04 (bits 6:4 and 1:0 read back), output control 0x08 (bits 2:0 read back), counter 0x14, compare A 0x18, compare B 0x1C, compare C 0x20 and compare D 0x24. All of these registers reset to 0.
- R3: Offsets 0x0C and 0x10, any other unlisted offset and any unlisted address read as 0, and writes to them are ignored.
- R4: Control bits 2:0 select the count source. Code 0 gives a tick on every clock. Codes 1, 2 and 3 use bit 2k-1 of a free-running 6-bit cycle counter that is cleared by reset, which gives periods of 4, 16 and 64 clocks. Codes 4 to 7 act as code 3.
- R5: Control bits 4:3 select the edge of the prescaled clock that counts: 0 rising, 1 falling, 2 or 3 both edges. With code 0 the edge setting has no effect.
- R6: While running, the counter rises by one on each tick and wraps at 0xFFFF. A write to the counter loads the written value and overrides a tick in the same cycle.
- R7: Control bits 7:5 select the clearing compare: 1 for A, 2 for B, 5 for C, 6 for D. Any other code never clears. When a tick finds the counter equal to the selected compare, the counter loads 0 instead of counting up, so the cycle lasts compare+1 ticks.
- R8: In the output-control code, bit 2 is the starting level and bits 1:0 are the match action (0 none, 1 drive 0, 2 drive 1, 3 invert). Writing the code sets the pin to the starting level in the next cycle, and this takes priority over any tick in the same cycle.
- R9: When mode bits 1:0 are not 2, a tick that finds the counter equal to compare A applies the match action to the pin.
- R10: When mode bits 1:0 are 2 (PWM), a tick that finds a clearing match returns the pin to the starting level. Otherwise a compare A match applies the match action. The return to the starting level wins when both matches occur on the same tick.
- R11: A stopped channel keeps its pin at the last driven level.
- R12: Output codes 0 and 4 hold the pin at a constant 0 or 1 while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| pwm_o | output | NUM_CH (3) | One pin per channel |

## Verification
The bench drives the prescaler through every code and edge choice while channels are running. A design with a wrong tap or edge phase would drift from the model within a few ticks. It steps the clearing compare through A, B, C, D and the reserved codes. A wrong decode would either wrap the counter early or never clear it. PWM runs include compare A equal to compare B and compare A equal to 0, so a design that gives the duty action priority would glitch the pin. Constant codes, output-code writes while running, counter writes at the wrap point and stop-and-hold are checked against the per-cycle model, which catches a pin that does not load at once or a counter that keeps counting.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int DATA_W   = 16;
  localparam int OFF_W    = 6;
  localparam int NUM_CMP  = 4;

  localparam logic [OFF_W-1:0] OFF_CTRL = 6'h00;
  localparam logic [OFF_W-1:0] OFF_MODE = 6'h04;
  localparam logic [OFF_W-1:0] OFF_IOC  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_CNT  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_CMP0 = 6'h18;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_INV  = 2'd3
  } pin_act_e;

  localparam logic [1:0] MODE_PWM = 2'd2;

  // clear-source code -> compare index match
  function automatic logic clr_hit(input logic [2:0] code,
                                   input logic [NUM_CMP-1:0] m);
    case (code)
      3'd1:    return m[0];
      3'd2:    return m[1];
      3'd5:    return m[2];
      3'd6:    return m[3];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mtp_prescaler.sv
module mtp_prescaler #(
  parameter int PRESC_CODES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [PRESC_CODES-1:0] rise_o,
  output logic [PRESC_CODES-1:0] fall_o
);
  localparam int PRE_W = 2 * (PRESC_CODES - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < PRESC_CODES; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign rise_o[k] = 1'b1;
      assign fall_o[k] = 1'b1;
    end else begin : g_div
      localparam int LW = 2 * k;
      logic [LW-1:0] low;
      assign low       = pre_q[LW-1:0];
      assign rise_o[k] = (low == LW'(1 << (LW - 1)));
      assign fall_o[k] = (low == '0);

      assert_edge_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o[k] && fall_o[k]));
      assert_edge_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o[k] |=> !rise_o[k]);
    end
  end
endmodule

// File: rtl/mtp_pin_ctrl.sv
module mtp_pin_ctrl
  import mtp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pwm_mode_i,
  input  logic       match_a_i,
  input  logic       clr_hit_i,
  input  logic [2:0] ioc_i,
  input  logic       ioc_wr_i,
  input  logic       ioc_wlvl_i,
  output logic       pin_o
);
  pin_act_e act;
  assign act = pin_act_e'(ioc_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o <= 1'b0;
    end else if (ioc_wr_i) begin
      pin_o <= ioc_wlvl_i;
    end else if (tick_i) begin
      if (pwm_mode_i && clr_hit_i) begin
        pin_o <= ioc_i[2];
      end else if (match_a_i) begin
        case (act)
          ACT_LOW:  pin_o <= 1'b0;
          ACT_HIGH: pin_o <= 1'b1;
          ACT_INV:  pin_o <= ~pin_o;
          default:  pin_o <= pin_o;
        endcase
      end
    end
  end

  assert_ioc_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ioc_wr_i |=> pin_o == $past(ioc_wlvl_i));
  assert_pwm_revert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioc_wr_i && tick_i && pwm_mode_i && clr_hit_i) |=> pin_o == $past(ioc_i[2]));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioc_wr_i && !tick_i) |=> $stable(pin_o));
  assert_const_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ioc_wr_i && ioc_i[1:0] == 2'd0) |=> $stable(pin_o));
endmodule

// File: rtl/mtp_channel.sv
module mtp_channel
  import mtp_pkg::*;
#(
  parameter int PRESC_CODES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [PRESC_CODES-1:0] rise_i,
  input  logic [PRESC_CODES-1:0] fall_i,
  input  logic                   sel_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   pin_o
);
  localparam int IDX_W = (PRESC_CODES > 1) ? $clog2(PRESC_CODES) : 1;

  logic [DATA_W-1:0] ctrl_q, cnt_q;
  logic [4:0]        mode_q;   // {bits 6:4, bits 1:0}
  logic [2:0]        ioc_q;
  logic [DATA_W-1:0] cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] match;
  logic              wr_ctrl, wr_mode, wr_ioc, wr_cnt;
  logic [IDX_W-1:0]  idx;
  logic              evt, tick, clr;

  assign wr_ctrl = sel_i && wr_i && off_i == OFF_CTRL;
  assign wr_mode = sel_i && wr_i && off_i == OFF_MODE;
  assign wr_ioc  = sel_i && wr_i && off_i == OFF_IOC;
  assign wr_cnt  = sel_i && wr_i && off_i == OFF_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_mode) mode_q <= {wdata_i[6:4], wdata_i[1:0]};
      if (wr_ioc)  ioc_q  <= wdata_i[2:0];
    end
  end

  for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
    localparam logic [OFF_W-1:0] OFF_J = OFF_CMP0 + OFF_W'(4 * j);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cmp_q[j] <= '0;
      else if (sel_i && wr_i && off_i == OFF_J)  cmp_q[j] <= wdata_i;
    end
    assign match[j] = (cnt_q == cmp_q[j]);
  end

  // count source: clamp reserved prescaler codes to the slowest tap
  assign idx = (int'(ctrl_q[2:0]) >= PRESC_CODES) ? IDX_W'(PRESC_CODES - 1)
                                                   : IDX_W'(ctrl_q[2:0]);
  always_comb begin
    case (ctrl_q[4:3])
      2'd0:    evt = rise_i[idx];
      2'd1:    evt = fall_i[idx];
      default: evt = rise_i[idx] | fall_i[idx];
    endcase
  end

  assign tick = run_i && evt;
  assign clr  = clr_hit(ctrl_q[7:5], match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata_i;
    else if (tick)   cnt_q <= clr ? '0 : cnt_q + 1'b1;
  end

  mtp_pin_ctrl u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .pwm_mode_i (mode_q[1:0] == MODE_PWM),
    .match_a_i  (match[0]),
    .clr_hit_i  (clr),
    .ioc_i      (ioc_q),
    .ioc_wr_i   (wr_ioc),
    .ioc_wlvl_i (wdata_i[2]),
    .pin_o      (pin_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (off_i)
        OFF_CTRL: rdata_o = ctrl_q;
        OFF_MODE: rdata_o = {9'd0, mode_q[4:2], 2'd0, mode_q[1:0]};
        OFF_IOC:  rdata_o = {13'd0, ioc_q};
        OFF_CNT:  rdata_o = cnt_q;
        6'h18:    rdata_o = cmp_q[0];
        6'h1C:    rdata_o = cmp_q[1];
        6'h20:    rdata_o = cmp_q[2];
        6'h24:    rdata_o = cmp_q[3];
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr && !wr_cnt) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && clr && !wr_cnt) |=> cnt_q == '0);
endmodule

// File: rtl/multi_timer_pwm.sv
module multi_timer_pwm
  import mtp_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int ADDR_W      = 8,
  parameter int PRESC_CODES = 4,
  parameter int CH_BASE     = 16,
  parameter int CH_STRIDE   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0] start_q;
  logic [NUM_CH-1:0] ch_hit;
  logic [OFF_W-1:0]  ch_off [NUM_CH];
  logic [DATA_W-1:0] ch_rd  [NUM_CH];
  logic [PRESC_CODES-1:0] rise, fall;
  logic              start_sel;

  assign start_sel = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   start_q <= '0;
    else if (start_sel && wr_en_i) start_q <= wdata_i[NUM_CH-1:0];
  end

  mtp_prescaler #(.PRESC_CODES(PRESC_CODES)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;
    assign ch_hit[g] = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + CH_STRIDE);
    assign ch_off[g] = OFF_W'(int'(addr_i) - BASE);

    mtp_channel #(.PRESC_CODES(PRESC_CODES)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (start_q[g]),
      .rise_i  (rise),
      .fall_i  (fall),
      .sel_i   (ch_hit[g]),
      .off_i   (ch_off[g]),
      .wr_i    (wr_en_i),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[g]),
      .pin_o   (pwm_o[g])
    );
  end

  always_comb begin
    rdata_o = start_sel ? 16'(start_q) : 16'd0;
    for (int i = 0; i < NUM_CH; i++) rdata_o = rdata_o | ch_rd[i];
  end

  assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) == CH_BASE + 12 || int'(addr_i) == CH_BASE + 16) |-> rdata_o == 16'd0);
  assert_start_wr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_sel && wr_en_i) |=> start_q == $past(wdata_i[NUM_CH-1:0]));
endmodule

// File: tb/tb_multi_timer_pwm.sv
module tb_multi_timer_pwm;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NCH-1:0] pwm;

  int checks = 0, fails = 0;
  string phase = "R2";

  always #5 clk = ~clk;

  multi_timer_pwm dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural reference model
  int m_start, m_pre;
  int m_ctrl[NCH], m_mode[NCH], m_ioc[NCH], m_cnt[NCH], m_pin[NCH];
  int m_cmp[NCH][4];

  function automatic int ch_of(int a);
    for (int n = 0; n < NCH; n++)
      if (a >= 16 + 64 * n && a < 80 + 64 * n) return n;
    return -1;
  endfunction

  function automatic int m_read(int a);
    int n, o;
    if (a == 0) return m_start;
    n = ch_of(a);
    if (n < 0) return 0;
    o = a - 16 - 64 * n;
    case (o)
      0:  return m_ctrl[n];
      4:  return m_mode[n];
      8:  return m_ioc[n];
      20: return m_cnt[n];
      24: return m_cmp[n][0];
      28: return m_cmp[n][1];
      32: return m_cmp[n][2];
      36: return m_cmp[n][3];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_pre = 0;
      for (int n = 0; n < NCH; n++) begin
        m_ctrl[n] = 0; m_mode[n] = 0; m_ioc[n] = 0; m_cnt[n] = 0; m_pin[n] = 0;
        for (int j = 0; j < 4; j++) m_cmp[n][j] = 0;
      end
    end else begin
      int pre_old, a, d, wn, wo;
      pre_old = m_pre;
      m_pre = (m_pre + 1) % 64;
      a = addr; d = wdata;
      wn = wr ? ch_of(a) : -1;
      wo = (wn >= 0) ? a - 16 - 64 * wn : -1;
      for (int n = 0; n < NCH; n++) begin
        int code, es, src, tick, ci, clr, ma, act, iw, cw;
        code = m_ctrl[n] & 7; if (code > 3) code = 3;
        es = (m_ctrl[n] >> 3) & 3;
        if (code == 0) src = 1;
        else begin
          int low, half, r, f;
          low = pre_old % (1 << (2 * code));
          half = 1 << (2 * code - 1);
          r = (low == half); f = (low == 0);
          src = (es == 0) ? r : (es == 1) ? f : (r | f);
        end
        tick = ((m_start >> n) & 1) && src;
        case ((m_ctrl[n] >> 5) & 7)
          1: ci = 0; 2: ci = 1; 5: ci = 2; 6: ci = 3; default: ci = -1;
        endcase
        clr = (ci >= 0) && (m_cnt[n] == m_cmp[n][ci]);
        ma = (m_cnt[n] == m_cmp[n][0]);
        act = m_ioc[n] & 3;
        iw = (wn == n) && (wo == 8);
        cw = (wn == n) && (wo == 20);
        if (iw) m_pin[n] = (d >> 2) & 1;
        else if (tick) begin
          if ((m_mode[n] & 3) == 2 && clr) m_pin[n] = (m_ioc[n] >> 2) & 1;
          else if (ma) begin
            if (act == 1) m_pin[n] = 0;
            else if (act == 2) m_pin[n] = 1;
            else if (act == 3) m_pin[n] = 1 - m_pin[n];
          end
        end
        if (cw) m_cnt[n] = d;
        else if (tick) m_cnt[n] = clr ? 0 : (m_cnt[n] + 1) & 16'hFFFF;
        if (wn == n) begin
          case (wo)
            0:  m_ctrl[n] = d;
            4:  m_mode[n] = d & 16'h0073;
            8:  m_ioc[n] = d & 7;
            24: m_cmp[n][0] = d;
            28: m_cmp[n][1] = d;
            32: m_cmp[n][2] = d;
            36: m_cmp[n][3] = d;
            default: ;
          endcase
        end
      end
      if (wr && a == 0) m_start = d & ((1 << NCH) - 1);
    end
  end

  task automatic chk_pins();
    checks++;
    for (int n = 0; n < NCH; n++)
      if (int'(pwm[n]) != m_pin[n]) begin
        fails++;
        $display("FAIL %s pin ch%0d actual=%0d expected=%0d at %0t",
                 phase, n, pwm[n], m_pin[n], $time);
      end
  endtask

  task automatic cyc(input logic w, input int a, input int d);
    @(negedge clk);
    chk_pins();
    addr = 8'(a); wr = w; wdata = 16'(d);
  endtask

  task automatic wreg(input int a, input int d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
  endtask

  task automatic rd(input int a, input string tag);
    int e;
    cyc(1'b0, a, 0);
    #1;
    e = m_read(a);
    checks++;
    if (int'(rdata) != e) begin
      fails++;
      $display("FAIL %s read 0x%02h actual=0x%04h expected=0x%04h", tag, a, rdata, e);
    end
  endtask

  function automatic int ba(int n); return 16 + 64 * n; endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(0, "R1"); rd(ba(0), "R2"); rd(ba(1) + 20, "R2"); rd(ba(2) + 8, "R2");
    // readback and masks (R2)
    wreg(ba(0), 16'hABCD); rd(ba(0), "R2");
    wreg(ba(0) + 4, 16'hFFFF); rd(ba(0) + 4, "R2");
    wreg(ba(1) + 8, 16'hFFFF); rd(ba(1) + 8, "R2");
    for (int j = 0; j < 4; j++) begin
      wreg(ba(2) + 24 + 4 * j, 100 + j); rd(ba(2) + 24 + 4 * j, "R2");
    end
    wreg(ba(1) + 20, 16'h1234); rd(ba(1) + 20, "R2");
    // reserved slots (R3)
    wreg(ba(0) + 12, 16'hFFFF); rd(ba(0) + 12, "R3");
    wreg(ba(1) + 16, 16'hFFFF); rd(ba(1) + 16, "R3");
    wreg(ba(2) + 2, 16'hFFFF);  rd(ba(2) + 2, "R3");
    wreg(ba(0) + 40, 16'h5555); rd(ba(0) + 40, "R3");
    rd(2, "R3"); rd(250, "R3");

    // PWM full rate, clear on B (R10)
    phase = "R10";
    wreg(ba(0), 2 << 5); wreg(ba(0) + 4, 2); wreg(ba(0) + 8, 5);
    wreg(ba(0) + 20, 0); wreg(ba(0) + 24, 3); wreg(ba(0) + 28, 9);
    wreg(0, 1); rd(0, "R1");
    idle(30);

    // prescaler and edge selection (R4, R5)
    phase = "R4";
    wreg(ba(1), (2 << 5) | 1); wreg(ba(1) + 4, 2); wreg(ba(1) + 8, 2);
    wreg(ba(1) + 20, 0); wreg(ba(1) + 24, 2); wreg(ba(1) + 28, 5);
    wreg(0, 3);
    idle(80);
    phase = "R5";
    wreg(ba(1), (2 << 5) | (1 << 3) | 1); idle(60);
    wreg(ba(1), (2 << 5) | (2 << 3) | 1); idle(60);
    wreg(ba(1), (2 << 5) | (3 << 3) | 2); idle(150);
    wreg(ba(1), (2 << 5) | (1 << 3)); idle(20);
    phase = "R4";
    wreg(ba(1) + 28, 3); wreg(ba(1), (2 << 5) | 7); idle(300);
    for (int i = 0; i < 6; i++) begin idle(11); rd(ba(1) + 20, "R4"); end

    // normal mode toggle on A with clear on A, falling edge div 4 (R9)
    phase = "R9";
    wreg(ba(2), (1 << 5) | (1 << 3) | 1); wreg(ba(2) + 4, 0); wreg(ba(2) + 8, 3);
    wreg(ba(2) + 20, 0); wreg(ba(2) + 24, 4);
    wreg(0, 7);
    idle(60);
    for (int i = 0; i < 8; i++) rd(ba(2) + 20, "R6");

    // clear source selection (R7)
    phase = "R7";
    wreg(ba(2), 5 << 5); wreg(ba(2) + 32, 6); wreg(ba(2) + 20, 0);
    for (int i = 0; i < 16; i++) rd(ba(2) + 20, "R7");
    wreg(ba(2), 6 << 5); wreg(ba(2) + 36, 3);
    for (int i = 0; i < 12; i++) rd(ba(2) + 20, "R7");
    wreg(ba(2), 3 << 5); wreg(ba(2) + 20, 0);
    for (int i = 0; i < 12; i++) rd(ba(2) + 20, "R7");
    wreg(ba(2), 0);
    for (int i = 0; i < 6; i++) rd(ba(2) + 20, "R7");

    // counter write while running, wrap (R6)
    phase = "R6";
    wreg(ba(2) + 20, 16'hFFFD);
    for (int i = 0; i < 6; i++) rd(ba(2) + 20, "R6");

    // duty equal to period, duty zero (R10)
    phase = "R10";
    wreg(ba(0) + 24, 9); idle(30);
    wreg(ba(0) + 24, 0); idle(30);
    wreg(ba(0) + 24, 4); wreg(ba(0), 1 << 5); idle(20);
    wreg(ba(0), 2 << 5);

    // output code write while running, constant codes (R8, R12)
    phase = "R8";
    idle(5); wreg(ba(0) + 8, 4); rd(ba(0) + 8, "R8");
    phase = "R12";
    idle(30); wreg(ba(0) + 8, 0); idle(30);
    phase = "R8";
    wreg(ba(0) + 8, 6); idle(3); wreg(ba(0) + 8, 1); idle(20);

    // stop holds counter and pin (R1, R11)
    phase = "R11";
    wreg(ba(0) + 8, 5); idle(7);
    wreg(0, 6); rd(0, "R1");
    rd(ba(0) + 20, "R1"); idle(30); rd(ba(0) + 20, "R1");
    wreg(0, 0); idle(40);
    rd(ba(1) + 20, "R11"); rd(ba(2) + 20, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule